// File: doc/BRIEF.md
# Byte-Serial Packet Interface Peripheral

This block is a memory-mapped network peripheral in which software moves whole Ethernet-sized frames one byte per register access. An inbound frame port fills a single receive buffer. Software then drains that buffer through a receive data register, and each read pops one byte. To transmit, software loads a length and then writes bytes into a transmit data register. When the last byte arrives, the block streams the assembled frame out of an outbound port that carries start and end markers.

A single interrupt-control register gathers the transmit-done, receive-done and self-test flags. A level interrupt is asserted while any of them is set. A write to this register acknowledges one flag, or triggers a soft reset of the whole block. A busy flag gates new inbound frames until software has acknowledged the previous event.

Top module: `byte_frame_nic`

## Requirements
- R1: After reset, busy reads 1, the receive and transmit counts read 0, interrupt control reads 0, `irq` is low, `in_ready` is low and `out_valid` is low.
- R2: The bus address is masked to its low 6 bits before decoding. The two ID words are at 0x00 and 0x04 (parameters), busy is bit 0 at 0x08, receive count is at 0x0C, transmit count is at 0x10, interrupt control is at 0x14, interrupt info is at 0x18 and always reads 0, receive data is at 0x1C and transmit data is at 0x20. The transmit data port and every unmapped offset read 0.
- R3: Interrupt control holds transmit-done in bit 0, receive-done in bit 1 and test in bit 31. `irq` is high exactly while any of them is set. A read returns the current value and then clears the test bit.
- R4: A write to interrupt control with bit 0 set clears only transmit-done. Otherwise, bit 1 set clears only receive-done. A write of zero changes no flag.
- R5: A write to interrupt control with bits 0 and 1 clear and bit 31 set performs a soft reset: counts, pointers and flags go to 0, any outbound stream is abandoned, busy becomes 1 and only the test bit is set.
- R6: After any write to interrupt control, busy equals the OR of the interrupt-control bits.
- R7: `in_ready` is high only while busy is 0 and the receive count is below BUF_BYTES (1514). A frame of BUF_BYTES bytes or more is dropped: the count, the flags and busy stay as they were.
- R8: When the last byte of an accepted frame is taken, the receive count becomes the frame length, the read pointer returns to the first byte, receive-done is set and busy becomes 1.
- R9: A read of the receive data port returns the next stored byte in bits 7:0 and decrements the receive count. When the count is 0, it returns 0 and changes nothing.
- R10: A write to the transmit count register loads the value if it is at most BUF_BYTES and loads 0 otherwise. It also restarts the transmit write pointer.
- R11: Each write to the transmit data port stores bits 7:0. When the number of stored bytes equals the transmit count, or reaches BUF_BYTES, the frame is sent: the count reads 0, transmit-done is set and busy becomes 1.
- R12: A sent frame leaves `out_data` in write order, with `out_sof` on the first byte and `out_eof` on the last. A byte is consumed only in a cycle where `out_ready` is high, and it is held stable otherwise.
- R13: Writes to the ID, busy, receive count, interrupt info and receive data offsets have no effect.
- R14: `bus_rdata` takes the read value at the clock edge where `bus_rd` is high, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt |
| in_valid | input | 1 | Inbound byte valid |
| in_data | input | 8 | Inbound byte |
| in_last | input | 1 | Inbound byte is the last of its frame |
| in_ready | output | 1 | Inbound port can take a byte |
| out_valid | output | 1 | Outbound byte valid |
| out_data | output | 8 | Outbound byte |
| out_sof | output | 1 | Outbound byte is the first of its frame |
| out_eof | output | 1 | Outbound byte is the last of its frame |
| out_ready | input | 1 | Outbound sink takes the byte |

## Verification
Inbound frames are driven at lengths of 3, 5, one below the buffer size, exactly the buffer size, and well past it. Comparing the outcomes separates the strict less-than accept rule from an off-by-one, and shows that an overflowing frame leaves no trace. Transmit frames are ended both by a matching count and by the buffer limit with a zero count. The transmit-count clip is tried below, at and above the limit. Interrupt-control writes combine bit 31 with bit 0 or bit 1 and use bit 31 alone, which tells the acknowledge priority apart from the soft reset. Holding `out_ready` low on a pending byte shows whether the outbound stream stalls or drops data.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

  // Register offsets after masking to 6 bits
  localparam logic [5:0] OFS_ID0    = 6'h00;
  localparam logic [5:0] OFS_ID1    = 6'h04;
  localparam logic [5:0] OFS_BUSY   = 6'h08;
  localparam logic [5:0] OFS_RXCNT  = 6'h0C;
  localparam logic [5:0] OFS_TXCNT  = 6'h10;
  localparam logic [5:0] OFS_ICTL   = 6'h14;
  localparam logic [5:0] OFS_IINFO  = 6'h18;
  localparam logic [5:0] OFS_RXDATA = 6'h1C;
  localparam logic [5:0] OFS_TXDATA = 6'h20;

  typedef struct packed {
    logic test;
    logic rx;
    logic tx;
  } ictl_t;

  function automatic logic [31:0] ictl_word(ictl_t f);
    return {f.test, 29'd0, f.rx, f.tx};
  endfunction

  // Soft reset request: test bit alone, with neither acknowledge bit
  function automatic logic is_soft_reset(logic [31:0] wv);
    return !wv[0] && !wv[1] && wv[31];
  endfunction

  // Priority decode of a write to interrupt control
  function automatic ictl_t ictl_after_write(ictl_t cur, logic [31:0] wv);
    ictl_t n;
    n = cur;
    if (wv[0])                 n.tx = 1'b0;
    else if (wv[1])            n.rx = 1'b0;
    else if (is_soft_reset(wv)) n = '{test: 1'b1, rx: 1'b0, tx: 1'b0};
    return n;
  endfunction

  function automatic int unsigned tx_len_clip(logic [31:0] v, int unsigned maxb);
    return (v <= maxb) ? v : 32'd0;
  endfunction

  function automatic logic tx_send_now(int unsigned written, int unsigned cnt,
                                       int unsigned maxb);
    return (written >= maxb) || (written == cnt);
  endfunction

  function automatic logic rx_can_accept(logic busy, int unsigned cnt, int unsigned maxb);
    return !busy && (cnt < maxb);
  endfunction

  function automatic logic rx_len_ok(int unsigned len, int unsigned maxb);
    return len < maxb;
  endfunction

endpackage

// File: rtl/sfp_rx_path.sv
module sfp_rx_path
  import sfp_pkg::*;
#(
  parameter int BUF_BYTES = 1514
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             busy,
  input  logic             pop,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             in_ready,
  output logic [$clog2(BUF_BYTES+1)-1:0] rx_cnt,
  output logic [7:0]       pop_byte,
  output logic             commit
);
  localparam int CNT_W = $clog2(BUF_BYTES + 1);
  localparam int AW    = $clog2(BUF_BYTES);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BUF_BYTES - 1);

  logic [7:0]       mem [BUF_BYTES];
  logic [CNT_W-1:0] wr_ptr, rd_ptr, cnt;
  logic             ovf;
  logic             take;
  logic [CNT_W-1:0] len;

  assign in_ready = rx_can_accept(busy, 32'(cnt), BUF_BYTES);
  assign take     = in_valid && in_ready && !soft_rst;
  assign len      = wr_ptr + CNT_W'(1);
  assign commit   = take && in_last && !ovf && rx_len_ok(32'(len), BUF_BYTES);
  assign rx_cnt   = cnt;
  assign pop_byte = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (take && !ovf) mem[wr_ptr[AW-1:0]] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0; rd_ptr <= '0; cnt <= '0; ovf <= 1'b0;
    end else if (soft_rst) begin
      wr_ptr <= '0; rd_ptr <= '0; cnt <= '0; ovf <= 1'b0;
    end else begin
      if (take) begin
        if (in_last) begin
          wr_ptr <= '0;
          ovf    <= 1'b0;
        end else if (wr_ptr == LAST_IDX) begin
          ovf <= 1'b1;
        end else begin
          wr_ptr <= len;
        end
      end
      if (commit) begin
        cnt    <= len;
        rd_ptr <= '0;
      end else if (pop && cnt != '0) begin
        cnt    <= cnt - CNT_W'(1);
        rd_ptr <= rd_ptr + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/sfp_tx_path.sv
module sfp_tx_path
  import sfp_pkg::*;
#(
  parameter int BUF_BYTES = 1514
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        set_len,
  input  logic        push,
  input  logic [31:0] wdata,
  input  logic        out_ready,
  output logic [$clog2(BUF_BYTES+1)-1:0] tx_cnt,
  output logic        sent,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_sof,
  output logic        out_eof
);
  localparam int CNT_W = $clog2(BUF_BYTES + 1);
  localparam int AW    = $clog2(BUF_BYTES);

  logic [7:0]       mem [BUF_BYTES];
  logic [CNT_W-1:0] cnt, wptr, olen, optr;
  logic [CNT_W-1:0] wnext;
  logic             streaming;

  assign wnext     = wptr + CNT_W'(1);
  assign sent      = push && tx_send_now(32'(wnext), 32'(cnt), BUF_BYTES);
  assign tx_cnt    = cnt;
  assign out_valid = streaming;
  assign out_data  = mem[optr[AW-1:0]];
  assign out_sof   = streaming && (optr == '0);
  assign out_eof   = streaming && (optr == olen - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (push) mem[wptr[AW-1:0]] <= wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; wptr <= '0; olen <= '0; optr <= '0; streaming <= 1'b0;
    end else if (soft_rst) begin
      cnt <= '0; wptr <= '0; olen <= '0; optr <= '0; streaming <= 1'b0;
    end else begin
      if (set_len) begin
        cnt  <= CNT_W'(tx_len_clip(wdata, BUF_BYTES));
        wptr <= '0;
      end else if (push) begin
        if (sent) begin
          cnt       <= '0;
          wptr      <= '0;
          olen      <= wnext;
          optr      <= '0;
          streaming <= 1'b1;
        end else begin
          wptr <= wnext;
        end
      end
      if (streaming && out_ready && !(push && sent)) begin
        if (out_eof) streaming <= 1'b0;
        else         optr      <= optr + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/sfp_ctl.sv
module sfp_ctl
  import sfp_pkg::*;
#(
  parameter int          BUF_BYTES = 1514,
  parameter int          ADDR_W    = 8,
  parameter logic [31:0] ID_WORD0  = 32'h4246_4e31,
  parameter logic [31:0] ID_WORD1  = 32'h0000_0100
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  input  logic [$clog2(BUF_BYTES+1)-1:0] rx_cnt,
  input  logic [$clog2(BUF_BYTES+1)-1:0] tx_cnt,
  input  logic [7:0]        rx_byte,
  input  logic              rx_commit,
  input  logic              tx_sent,
  output logic              busy,
  output logic              soft_rst,
  output logic              rx_pop,
  output logic              tx_set_len,
  output logic              tx_push,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int CNT_W = $clog2(BUF_BYTES + 1);

  logic [5:0]  ofs;
  ictl_t       ictl, ictl_n;
  logic        busy_n;
  logic        wr_ictl;
  logic [31:0] rd_val;

  assign ofs        = 6'(bus_addr & ADDR_W'(6'h3f));
  assign wr_ictl    = bus_wr && (ofs == OFS_ICTL);
  assign soft_rst   = wr_ictl && is_soft_reset(bus_wdata);
  assign rx_pop     = bus_rd && (ofs == OFS_RXDATA);
  assign tx_set_len = bus_wr && (ofs == OFS_TXCNT);
  assign tx_push    = bus_wr && (ofs == OFS_TXDATA);
  assign irq        = ictl.test || ictl.rx || ictl.tx;

  always_comb begin
    ictl_n = ictl;
    busy_n = busy;
    if (bus_rd && ofs == OFS_ICTL) ictl_n.test = 1'b0;
    if (wr_ictl) ictl_n = ictl_after_write(ictl_n, bus_wdata);
    if (!soft_rst) begin
      if (rx_commit) ictl_n.rx = 1'b1;
      if (tx_sent)   ictl_n.tx = 1'b1;
    end
    if (wr_ictl) busy_n = ictl_n.test || ictl_n.rx || ictl_n.tx;
    if (rx_commit || tx_sent) busy_n = 1'b1;
  end

  always_comb begin
    unique case (ofs)
      OFS_ID0:    rd_val = ID_WORD0;
      OFS_ID1:    rd_val = ID_WORD1;
      OFS_BUSY:   rd_val = {31'd0, busy};
      OFS_RXCNT:  rd_val = 32'(rx_cnt);
      OFS_TXCNT:  rd_val = 32'(tx_cnt);
      OFS_ICTL:   rd_val = ictl_word(ictl);
      OFS_RXDATA: rd_val = (rx_cnt != CNT_W'(0)) ? {24'd0, rx_byte} : 32'd0;
      default:    rd_val = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ictl      <= '0;
      busy      <= 1'b1;
      bus_rdata <= '0;
    end else begin
      ictl <= ictl_n;
      busy <= busy_n;
      if (bus_rd) bus_rdata <= rd_val;
    end
  end
endmodule

// File: rtl/byte_frame_nic.sv
module byte_frame_nic #(
  parameter int          BUF_BYTES = 1514,
  parameter int          ADDR_W    = 8,
  parameter logic [31:0] ID_WORD0  = 32'h4246_4e31,
  parameter logic [31:0] ID_WORD1  = 32'h0000_0100
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_sof,
  output logic              out_eof,
  input  logic              out_ready
);
  localparam int CNT_W = $clog2(BUF_BYTES + 1);

  // Named internal events, also observed by the bound checker
  logic             busy, soft_rst, rx_pop, rx_commit;
  logic             tx_set_len, tx_push, tx_sent;
  logic [CNT_W-1:0] rx_cnt, tx_cnt;
  logic [7:0]       rx_byte;

  sfp_ctl #(
    .BUF_BYTES(BUF_BYTES), .ADDR_W(ADDR_W),
    .ID_WORD0(ID_WORD0), .ID_WORD1(ID_WORD1)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .rx_byte(rx_byte),
    .rx_commit(rx_commit), .tx_sent(tx_sent),
    .busy(busy), .soft_rst(soft_rst), .rx_pop(rx_pop),
    .tx_set_len(tx_set_len), .tx_push(tx_push),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  sfp_rx_path #(.BUF_BYTES(BUF_BYTES)) u_rx (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .busy(busy), .pop(rx_pop),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .rx_cnt(rx_cnt), .pop_byte(rx_byte), .commit(rx_commit)
  );

  sfp_tx_path #(.BUF_BYTES(BUF_BYTES)) u_tx (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .set_len(tx_set_len), .push(tx_push), .wdata(bus_wdata), .out_ready(out_ready),
    .tx_cnt(tx_cnt), .sent(tx_sent),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof)
  );
endmodule

// File: rtl/sfp_checker.sv
module sfp_checker #(
  parameter int BUF_BYTES = 1514,
  parameter int ADDR_W    = 8
)(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [31:0]       bus_rdata,
  input logic              irq,
  input logic              busy,
  input logic              in_ready,
  input logic              rx_commit,
  input logic              tx_sent,
  input logic              soft_rst,
  input logic [$clog2(BUF_BYTES+1)-1:0] rx_cnt,
  input logic [$clog2(BUF_BYTES+1)-1:0] tx_cnt,
  input logic              out_valid,
  input logic              out_ready,
  input logic [7:0]        out_data,
  input logic              out_sof,
  input logic              out_eof
);
  logic [5:0] ofs;
  assign ofs = 6'(bus_addr & ADDR_W'(6'h3f));

  AST_TX_DONE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sent |=> irq && busy && tx_cnt == '0);                          // R11
  AST_RX_COMMIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_commit |=> busy && irq && !in_ready);                           // R8
  AST_BUSY_BLOCKS_INBOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);                                               // R7
  AST_RXCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(rx_cnt) < BUF_BYTES);                                          // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !soft_rst |=>
      out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof)); // R12
  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && ofs == 6'h1C && rx_cnt == '0 && !rx_commit && !soft_rst |=>
      rx_cnt == '0 && bus_rdata == 32'd0);                             // R9
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> busy && irq && rx_cnt == '0 && tx_cnt == '0 && !out_valid); // R5
  AST_ICTL_WR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && ofs == 6'h14 |=> busy == irq);                           // R6
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));                                   // R14
endmodule

bind byte_frame_nic sfp_checker #(.BUF_BYTES(BUF_BYTES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .irq(irq), .busy(busy), .in_ready(in_ready),
  .rx_commit(rx_commit), .tx_sent(tx_sent), .soft_rst(soft_rst),
  .rx_cnt(rx_cnt), .tx_cnt(tx_cnt),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_sof(out_sof), .out_eof(out_eof)
);

// File: tb/sim_byte_frame_nic.sv
`timescale 1ns/1ps
module sim_byte_frame_nic;
  localparam int          MAXB = 1514;
  localparam logic [31:0] ID0  = 32'h4246_4e31;
  localparam logic [31:0] ID1  = 32'h0000_0100;
  localparam logic [7:0] A_ID0 = 8'h00, A_ID1 = 8'h04, A_BUSY = 8'h08, A_RXCNT = 8'h0C,
                         A_TXCNT = 8'h10, A_ICTL = 8'h14, A_IINFO = 8'h18,
                         A_RXDATA = 8'h1C, A_TXDATA = 8'h20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, in_ready, out_valid, out_sof, out_eof;
  logic        in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [7:0]  in_data = '0, out_data;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  byte_frame_nic #(.BUF_BYTES(MAXB), .ADDR_W(8), .ID_WORD0(ID0), .ID_WORD1(ID1)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
    .out_ready(out_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_read(a, v);
    chk(req, v, exp);
  endtask

  // Drives a frame one byte per cycle; the caller has checked in_ready
  task automatic send_in(input int len, input int seed);
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1; in_data = 8'(i + seed); in_last = (i == len - 1);
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic drain(input string req, input int n, input int base);
    int errs = 0;
    out_ready = 1'b1;
    for (int i = 0; i < n; i++) begin
      if (!out_valid || out_data !== 8'(base + i) || out_sof !== (i == 0) ||
          out_eof !== (i == n - 1)) errs++;
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(req, 32'(errs), 32'd0);
    chk(req, {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 in_ready", {31'd0, in_ready}, 0);
    chk("R1 out_valid", {31'd0, out_valid}, 0);
    rd_chk("R1 busy", A_BUSY, 1);
    rd_chk("R1 rxcnt", A_RXCNT, 0);
    rd_chk("R1 txcnt", A_TXCNT, 0);
    rd_chk("R1 ictl", A_ICTL, 0);
    rd_chk("R2 id0", A_ID0, ID0);
    rd_chk("R2 id1", A_ID1, ID1);
    rd_chk("R2 iinfo", A_IINFO, 0);
    rd_chk("R2 unmapped", 8'h24, 0);
    rd_chk("R2 alias busy", 8'h48, 1);
    bus_addr = A_ID0; @(negedge clk);
    chk("R14 rdata held", bus_rdata, 1);
  endtask

  task automatic t_rx_basic;
    bus_write(A_ICTL, 0);
    rd_chk("R6 busy cleared", A_BUSY, 0);
    chk("R7 ready", {31'd0, in_ready}, 1);
    send_in(5, 8'h30);
    chk("R8 irq", {31'd0, irq}, 1);
    chk("R8 ready low", {31'd0, in_ready}, 0);
    rd_chk("R8 rxcnt", A_RXCNT, 5);
    rd_chk("R8 busy", A_BUSY, 1);
    rd_chk("R3 ictl rx", A_ICTL, 32'h2);
    for (int i = 0; i < 5; i++) rd_chk("R9 byte", A_RXDATA, 32'(8'h30 + i));
    rd_chk("R9 empty read", A_RXDATA, 0);
    rd_chk("R9 rxcnt zero", A_RXCNT, 0);
  endtask

  task automatic t_tx_basic;
    bus_write(A_ICTL, 32'h2);
    chk("R3 irq low", {31'd0, irq}, 0);
    rd_chk("R6 busy", A_BUSY, 0);
    bus_write(A_TXCNT, 4);
    rd_chk("R10 txcnt", A_TXCNT, 4);
    for (int i = 0; i < 3; i++) bus_write(A_TXDATA, 32'hABCD_0050 + 32'(i));
    chk("R11 not sent", {31'd0, irq}, 0);
    chk("R11 no stream", {31'd0, out_valid}, 0);
    bus_write(A_TXDATA, 32'hABCD_0053);
    chk("R11 irq", {31'd0, irq}, 1);
    chk("R12 first", {out_valid, out_sof, out_eof, out_data}, {3'b110, 8'h50});
    @(negedge clk); @(negedge clk);
    chk("R12 stall", {out_valid, out_sof, out_data}, {2'b11, 8'h50});
    drain("R12 stream", 4, 8'h50);
    rd_chk("R11 txcnt", A_TXCNT, 0);
    rd_chk("R11 ictl", A_ICTL, 32'h1);
    rd_chk("R11 busy", A_BUSY, 1);
  endtask

  task automatic t_priority;
    bus_write(A_ICTL, 32'h8000_0001);
    rd_chk("R4 bit0 wins", A_ICTL, 0);
    rd_chk("R6 busy", A_BUSY, 0);
    send_in(3, 8'h70);
    bus_write(A_TXCNT, 1);
    bus_write(A_TXDATA, 32'h99);
    drain("R12 single", 1, 8'h99);
    rd_chk("R3 both", A_ICTL, 32'h3);
    bus_write(A_ICTL, 32'h3);
    rd_chk("R4 tx only", A_ICTL, 32'h2);
    rd_chk("R4 busy kept", A_BUSY, 1);
    bus_write(A_ICTL, 32'h8000_0002);
    rd_chk("R4 rx cleared", A_ICTL, 0);
    rd_chk("R4 no reset", A_RXCNT, 3);
    rd_chk("R9 after ack", A_RXDATA, 32'h70);
  endtask

  task automatic t_clip;
    bus_write(A_TXCNT, 1515);
    rd_chk("R10 above", A_TXCNT, 0);
    bus_write(A_TXCNT, 1514);
    rd_chk("R10 at", A_TXCNT, 1514);
    bus_write(A_TXCNT, 32'h0001_0002);
    rd_chk("R10 wide", A_TXCNT, 0);
  endtask

  task automatic t_rx_drop;
    chk("R7 ready", {31'd0, in_ready}, 1);
    send_in(MAXB, 0);
    rd_chk("R7 drop max cnt", A_RXCNT, 2);
    rd_chk("R7 drop max ictl", A_ICTL, 0);
    send_in(1600, 0);
    rd_chk("R7 drop long cnt", A_RXCNT, 2);
    rd_chk("R7 drop long busy", A_BUSY, 0);
    send_in(MAXB - 1, 8'h11);
    rd_chk("R8 max-1 cnt", A_RXCNT, MAXB - 1);
    rd_chk("R8 max-1 ictl", A_ICTL, 32'h2);
    rd_chk("R9 first byte", A_RXDATA, 32'h11);
    rd_chk("R9 decrement", A_RXCNT, MAXB - 2);
    bus_write(A_ICTL, 32'h2);
  endtask

  task automatic t_tx_max;
    for (int i = 0; i < MAXB - 1; i++) bus_write(A_TXDATA, 32'(i));
    chk("R11 below max", {30'd0, irq, out_valid}, 0);
    bus_write(A_TXDATA, 32'(MAXB - 1));
    chk("R11 max send", {31'd0, irq}, 1);
    drain("R12 max stream", MAXB, 0);
    rd_chk("R11 max cnt", A_TXCNT, 0);
    bus_write(A_ICTL, 32'h1);
  endtask

  task automatic t_soft_reset;
    bus_write(A_TXCNT, 7);
    bus_write(A_TXDATA, 1);
    send_in(4, 0);
    bus_write(A_ICTL, 32'h8000_0000);
    chk("R5 irq", {31'd0, irq}, 1);
    chk("R5 ready", {31'd0, in_ready}, 0);
    rd_chk("R5 busy", A_BUSY, 1);
    rd_chk("R5 rxcnt", A_RXCNT, 0);
    rd_chk("R5 txcnt", A_TXCNT, 0);
    rd_chk("R3 test read", A_ICTL, 32'h8000_0000);
    chk("R3 test cleared irq", {31'd0, irq}, 0);
    rd_chk("R3 test gone", A_ICTL, 0);
    rd_chk("R5 busy stays", A_BUSY, 1);
    bus_write(A_ICTL, 0);
    rd_chk("R6 ack zero", A_BUSY, 0);
  endtask

  task automatic t_readonly;
    bus_write(A_BUSY, 1);
    rd_chk("R13 busy", A_BUSY, 0);
    bus_write(A_RXCNT, 5);
    rd_chk("R13 rxcnt", A_RXCNT, 0);
    bus_write(A_ID0, 0);
    rd_chk("R13 id0", A_ID0, ID0);
    bus_write(A_RXDATA, 32'h55);
    bus_write(A_IINFO, 1);
    chk("R13 irq", {31'd0, irq}, 0);
    rd_chk("R13 rxcnt after", A_RXCNT, 0);
    rd_chk("R2 txdata reads 0", A_TXDATA, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rx_basic();
    t_tx_basic();
    t_priority();
    t_clip();
    t_rx_drop();
    t_tx_max();
    t_soft_reset();
    t_readonly();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule